// File: doc/BRIEF.md
# External ROM Chip-Select Controller with Bus Sizing

This block connects a 32-bit internal host request port to a bank of external ROM or flash parts. It decodes three 64 MB windows. Window 0 holds the boot device. Its device width and its external data bus are taken from strap pins when power-good is first seen high. Windows 1 and 2 are optional and are brought up through a small configuration port.

For each accepted host word access, the controller runs one, two or four device beats, depending on the device width of the selected window. It drives the byte address, a single chip select and either output enable or write enable. It holds each beat for a programmable number of wait cycles. On reads it assembles the returned bytes into one word. A separate, shorter wait count applies to beats that stay inside an already open 8-byte page. A data-bus select output tells the pin multiplexer which external bus carries the data.

Requests that hit no enabled window, and writes to a protected window, finish without touching the device pins. Illegal width and bus combinations are refused at configuration time.

Top module: `xrom_bridge`

## Requirements
- R1: After reset, all three chip selects, output enable and write enable are high, req_ready is 1, and resp_valid, cfg_err and acc_err are 0.
- R2: The boot straps are latched once, on the first power-good high after reset: strap_width (0 = 8 bit, 1 = 16 bit, 2 = 32 bit) and strap_bus (0 = general-purpose bus, 1 = SDRAM data bus). Later strap changes have no effect. Before the latch, the boot window is disabled. The boot window responds when address bits [31:26] equal 6'h3F.
- R3: A window is selected when it is enabled and address bits [31:26] equal its base field. If several windows match, window 0 wins over 1, and 1 wins over 2. A request that matches no window returns resp_err=1 with no chip select asserted.
- R4: Configuration word fields are: bit 0 enable, bits [2:1] width code, bit 3 bus, bit 4 page mode, bit 5 write protect, bits [8:6] full wait, bits [11:9] page wait, bits [17:12] base. cfg_sel 1 and 2 write the optional windows. cfg_sel 0 updates only the page, protect and wait fields of the boot window. An enabling write with width 32 on the general-purpose bus, or with width code 3, leaves that window disabled and sets the sticky cfg_err. An illegal strap combination does the same for the boot window.
- R5: A host word access runs 4 beats on an 8-bit window, 2 on a 16-bit window and 1 on a 32-bit window. Beat addresses step by the device width from the word-aligned address. Read bytes are assembled little-endian into a single one-cycle response.
- R6: A beat keeps its strobes asserted for wait+1 cycles. resp_valid appears the sum of all beat lengths after the accepting clock edge. An error response appears on the cycle right after acceptance.
- R7: With page mode on, a read beat uses the page wait when its 8-byte page equals the page of the last read beat, in the same window, with no write, error or configuration write in between. Any other beat uses the full wait.
- R8: A write to a window with write protect set produces no strobe, returns resp_err=1 and sets the sticky acc_err. acc_err is also set by window misses.
- R9: A write beat holds rom_we_n low and rom_oe_n high. The low device lanes of rom_dout carry the host bytes belonging to that beat.
- R10: While a chip select is low, rom_dbus_sel equals the bus field of the selected window.
- R11: At most one chip select is low at a time, and output enable and write enable are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Power-good indication, asynchronous |
| strap_width | input | 2 | Boot device width strap |
| strap_bus | input | 1 | Boot data bus strap |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Window addressed by the configuration write |
| cfg_wdata | input | 18 | Configuration word |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | Host request is a write |
| req_waddr | input | 30 | Host word address (byte address bits 31:2) |
| req_wdata | input | 32 | Host write data |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_rdata | output | 32 | Assembled read data |
| resp_err | output | 1 | Response is an error |
| cfg_err | output | 1 | Sticky configuration error |
| acc_err | output | 1 | Sticky access error |
| rom_cs_n | output | 3 | Active-low chip selects, one per window |
| rom_oe_n | output | 1 | Active-low output enable |
| rom_we_n | output | 1 | Active-low write enable |
| rom_addr | output | 26 | Device byte address |
| rom_dout | output | 32 | Write data toward the device |
| rom_din | input | 32 | Read data from the device |
| rom_dbus_sel | output | 1 | External data bus select, 0 general-purpose, 1 SDRAM |

## Verification
The bench targets the page-state corners:
- It reads the next word of an open page and expects only short beats. A design that forgot the page would show the full latency here.
- It crosses into a new page and expects the full wait again. A design that compared too few address bits would come back early.
- It performs a write and then rereads the same page. A controller that keeps page state across writes would answer too fast.

It also changes the straps after they are latched, and it sets two windows to the same base. A broken latch shows up as the wrong beat count. A wrong priority shows up as the wrong chip select. A 32-bit window on the general-purpose bus must then miss, and a protected write must leave rom_we_n untouched. An implementation that accepted the illegal setting, or strobed the protected device, fails those checks.

// File: rtl/xrom_pkg.sv
package xrom_pkg;
  localparam int NWIN   = 3;
  localparam int IDX_W  = $clog2(NWIN);
  localparam int ADDR_W = 26;
  localparam int WAIT_W = 3;
  localparam int BASE_W = 32 - ADDR_W;
  localparam int CFG_W  = 6 + 2 * WAIT_W + BASE_W;
  localparam int TAG_W  = ADDR_W - 3;
  localparam int HWA_W  = 30;

  typedef struct packed {
    logic [1:0]        width;
    logic              bus;
    logic              page;
    logic              wp;
    logic [WAIT_W-1:0] wfull;
    logic [WAIT_W-1:0] wpage;
  } acc_cfg_t;

  typedef struct packed {
    logic              en;
    logic [BASE_W-1:0] base;
    acc_cfg_t          acc;
  } win_cfg_t;

  typedef enum logic [1:0] {SQ_IDLE, SQ_ACC, SQ_RSP} seq_st_e;

  function automatic logic width_ok(input logic [1:0] w, input logic bus);
    return (w == 2'd0) || (w == 2'd1) || ((w == 2'd2) && bus);
  endfunction

  function automatic win_cfg_t unpack_cfg(input logic [CFG_W-1:0] d);
    win_cfg_t c;
    c.en        = d[0];
    c.acc.width = d[2:1];
    c.acc.bus   = d[3];
    c.acc.page  = d[4];
    c.acc.wp    = d[5];
    c.acc.wfull = d[6 +: WAIT_W];
    c.acc.wpage = d[6 + WAIT_W +: WAIT_W];
    c.base      = d[6 + 2 * WAIT_W +: BASE_W];
    return c;
  endfunction

  function automatic logic [1:0] last_beat(input logic [1:0] w);
    case (w)
      2'd0:    return 2'd3;
      2'd1:    return 2'd1;
      default: return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/xrom_cfg_regs.sv
module xrom_cfg_regs
  import xrom_pkg::*;
#(
  parameter logic [BASE_W-1:0] BOOT_BASE  = '1,
  parameter logic [WAIT_W-1:0] BOOT_WAIT  = '1,
  parameter logic [WAIT_W-1:0] BOOT_PWAIT = '1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   pwr_good,
  input  logic [1:0]             strap_width,
  input  logic                   strap_bus,
  input  logic                   cfg_we,
  input  logic [IDX_W-1:0]       cfg_sel,
  input  logic [CFG_W-1:0]       cfg_wdata,
  output win_cfg_t [NWIN-1:0]    cfg_o,
  output logic                   cfg_err
);
  logic pg_s1, pg_s2, strap_done, capture;
  logic [1:0] boot_w_q;
  logic boot_bus_q, boot_ok_q;
  logic boot_page_q, boot_wp_q, boot_page_d, boot_wp_d;
  logic [WAIT_W-1:0] boot_fw_q, boot_pw_q, boot_fw_d, boot_pw_d;
  logic [NWIN-1:0] bad;
  logic cfg_err_d;
  win_cfg_t wr_cfg;

  assign wr_cfg  = unpack_cfg(cfg_wdata);
  assign capture = pg_s2 && !strap_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_s1 <= 1'b0;
      pg_s2 <= 1'b0;
    end else begin
      pg_s1 <= pwr_good;
      pg_s2 <= pg_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_done <= 1'b0;
      boot_w_q   <= 2'd0;
      boot_bus_q <= 1'b0;
      boot_ok_q  <= 1'b0;
    end else if (capture) begin
      strap_done <= 1'b1;
      boot_w_q   <= strap_width;
      boot_bus_q <= strap_bus;
      boot_ok_q  <= width_ok(strap_width, strap_bus);
    end
  end

  always_comb begin
    boot_page_d = boot_page_q;
    boot_wp_d   = boot_wp_q;
    boot_fw_d   = boot_fw_q;
    boot_pw_d   = boot_pw_q;
    if (cfg_we && (cfg_sel == '0)) begin
      boot_page_d = wr_cfg.acc.page;
      boot_wp_d   = wr_cfg.acc.wp;
      boot_fw_d   = wr_cfg.acc.wfull;
      boot_pw_d   = wr_cfg.acc.wpage;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_page_q <= 1'b0;
      boot_wp_q   <= 1'b0;
      boot_fw_q   <= BOOT_WAIT;
      boot_pw_q   <= BOOT_PWAIT;
    end else begin
      boot_page_q <= boot_page_d;
      boot_wp_q   <= boot_wp_d;
      boot_fw_q   <= boot_fw_d;
      boot_pw_q   <= boot_pw_d;
    end
  end

  assign cfg_o[0] = '{en: strap_done && boot_ok_q, base: BOOT_BASE,
                      acc: '{width: boot_w_q, bus: boot_bus_q, page: boot_page_q,
                             wp: boot_wp_q, wfull: boot_fw_q, wpage: boot_pw_q}};
  assign bad[0] = capture && !width_ok(strap_width, strap_bus);

  for (genvar gi = 1; gi < NWIN; gi++) begin : g_opt
    win_cfg_t win_q, win_d;
    logic     hit_sel;
    assign hit_sel = cfg_we && (cfg_sel == IDX_W'(gi));
    always_comb begin
      win_d = win_q;
      if (hit_sel) begin
        win_d    = wr_cfg;
        win_d.en = wr_cfg.en && width_ok(wr_cfg.acc.width, wr_cfg.acc.bus);
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) win_q <= '0;
      else        win_q <= win_d;
    end
    assign cfg_o[gi] = win_q;
    assign bad[gi]   = hit_sel && wr_cfg.en && !width_ok(wr_cfg.acc.width, wr_cfg.acc.bus);
  end

  assign cfg_err_d = cfg_err || (|bad);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_err <= 1'b0;
    else        cfg_err <= cfg_err_d;
  end

  AST_BOOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    strap_done |=> ($stable(boot_w_q) && $stable(boot_bus_q))); // R2
  AST_CFGERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err); // R4
endmodule

// File: rtl/xrom_decode.sv
module xrom_decode
  import xrom_pkg::*;
(
  input  logic [NWIN-1:0]             win_en,
  input  logic [NWIN-1:0][BASE_W-1:0] win_base,
  input  logic [BASE_W-1:0]           hi_addr,
  output logic                        hit,
  output logic [IDX_W-1:0]            idx
);
  logic [NWIN-1:0] match;

  for (genvar gi = 0; gi < NWIN; gi++) begin : g_match
    assign match[gi] = win_en[gi] && (win_base[gi] == hi_addr);
  end

  always_comb begin
    hit = |match;
    idx = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (match[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/xrom_seq.sv
module xrom_seq
  import xrom_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-3:0]    req_wlo,
  input  logic [31:0]          req_wdata,
  input  logic                 dec_hit,
  input  logic [IDX_W-1:0]     dec_idx,
  input  acc_cfg_t             dec_acc,
  input  logic                 cfg_touch,
  output logic                 req_ready,
  output logic                 resp_valid,
  output logic [31:0]          resp_rdata,
  output logic                 resp_err,
  output logic                 acc_err,
  output logic [NWIN-1:0]      rom_cs_n,
  output logic                 rom_oe_n,
  output logic                 rom_we_n,
  output logic [ADDR_W-1:0]    rom_addr,
  output logic [31:0]          rom_dout,
  input  logic [31:0]          rom_din,
  output logic                 rom_dbus_sel
);
  seq_st_e            st_q, st_d;
  logic [WAIT_W-1:0]  cnt_q, cnt_d;
  logic [1:0]         beat_q, beat_d;
  logic [IDX_W-1:0]   idx_q, idx_d, pgw_q, pgw_d;
  logic               wr_q, wr_d, err_q, err_d, pgv_q, pgv_d, aerr_q, aerr_d;
  logic [ADDR_W-1:0]  base_q, base_d;
  logic [31:0]        wdata_q, wdata_d, rdata_q, rdata_d;
  acc_cfg_t           cur_q, cur_d;
  logic [TAG_W-1:0]   pgt_q, pgt_d;
  logic [ADDR_W-1:0]  beat_off, nxt_off, beat_addr, nxt_addr;
  logic               acc_hit, nxt_hit, in_acc;

  assign beat_off  = ADDR_W'(beat_q) << cur_q.width;
  assign nxt_off   = ADDR_W'(beat_q + 2'd1) << cur_q.width;
  assign beat_addr = base_q + beat_off;
  assign nxt_addr  = base_q + nxt_off;
  assign acc_hit   = dec_acc.page && !req_write && pgv_q && (pgw_q == dec_idx) &&
                     (pgt_q == req_wlo[ADDR_W-3:1]);
  assign nxt_hit   = cur_q.page && !wr_q &&
                     (nxt_addr[ADDR_W-1:3] == beat_addr[ADDR_W-1:3]);
  assign in_acc    = (st_q == SQ_ACC);

  always_comb begin
    st_d = st_q;       cnt_d = cnt_q;     beat_d = beat_q;   idx_d = idx_q;
    wr_d = wr_q;       base_d = base_q;   wdata_d = wdata_q; rdata_d = rdata_q;
    err_d = err_q;     cur_d = cur_q;     pgv_d = pgv_q;     pgw_d = pgw_q;
    pgt_d = pgt_q;     aerr_d = aerr_q;
    unique case (st_q)
      SQ_IDLE: begin
        if (req_valid) begin
          wr_d    = req_write;
          base_d  = {req_wlo, 2'b00};
          wdata_d = req_wdata;
          rdata_d = '0;
          beat_d  = 2'd0;
          idx_d   = dec_idx;
          cur_d   = dec_acc;
          if (!dec_hit || (req_write && dec_acc.wp)) begin
            st_d   = SQ_RSP;
            err_d  = 1'b1;
            aerr_d = 1'b1;
            pgv_d  = 1'b0;
          end else begin
            st_d  = SQ_ACC;
            err_d = 1'b0;
            cnt_d = acc_hit ? dec_acc.wpage : dec_acc.wfull;
            if (req_write) pgv_d = 1'b0;
          end
        end
      end
      SQ_ACC: begin
        if (cnt_q == '0) begin
          if (!wr_q) begin
            case (cur_q.width)
              2'd0:    rdata_d[{beat_q, 3'b000} +: 8]     = rom_din[7:0];
              2'd1:    rdata_d[{beat_q[0], 4'b0000} +: 16] = rom_din[15:0];
              default: rdata_d = rom_din;
            endcase
            pgv_d = 1'b1;
            pgw_d = idx_q;
            pgt_d = beat_addr[ADDR_W-1:3];
          end
          if (beat_q == last_beat(cur_q.width)) begin
            st_d = SQ_RSP;
          end else begin
            beat_d = beat_q + 2'd1;
            cnt_d  = nxt_hit ? cur_q.wpage : cur_q.wfull;
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      SQ_RSP:  st_d = SQ_IDLE;
      default: st_d = SQ_IDLE;
    endcase
    if (cfg_touch) pgv_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SQ_IDLE;  cnt_q <= '0;   beat_q <= '0;  idx_q <= '0;
      wr_q <= 1'b0;     base_q <= '0;  wdata_q <= '0; rdata_q <= '0;
      err_q <= 1'b0;    cur_q <= '0;   pgv_q <= 1'b0; pgw_q <= '0;
      pgt_q <= '0;      aerr_q <= 1'b0;
    end else begin
      st_q <= st_d;     cnt_q <= cnt_d;   beat_q <= beat_d;   idx_q <= idx_d;
      wr_q <= wr_d;     base_q <= base_d; wdata_q <= wdata_d; rdata_q <= rdata_d;
      err_q <= err_d;   cur_q <= cur_d;   pgv_q <= pgv_d;     pgw_q <= pgw_d;
      pgt_q <= pgt_d;   aerr_q <= aerr_d;
    end
  end

  for (genvar gi = 0; gi < NWIN; gi++) begin : g_cs
    assign rom_cs_n[gi] = !(in_acc && (idx_q == IDX_W'(gi)));
  end

  assign req_ready    = (st_q == SQ_IDLE);
  assign resp_valid   = (st_q == SQ_RSP);
  assign resp_rdata   = rdata_q;
  assign resp_err     = err_q;
  assign acc_err      = aerr_q;
  assign rom_oe_n     = !(in_acc && !wr_q);
  assign rom_we_n     = !(in_acc && wr_q);
  assign rom_addr     = beat_addr;
  assign rom_dout     = wdata_q >> {beat_off[1:0], 3'b000};
  assign rom_dbus_sel = cur_q.bus;

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~rom_cs_n) && !(!rom_oe_n && !rom_we_n)); // R11
  AST_WP_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_we_n |-> !cur_q.wp); // R8
  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid); // R5
  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_acc && cnt_q != '0) |=> (in_acc && $stable(rom_addr))); // R6
  AST_NO_WIDE_GP: assert property (@(posedge clk) disable iff (!rst_n)
    in_acc |-> width_ok(cur_q.width, cur_q.bus)); // R4
  AST_ACCERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |=> acc_err); // R8
endmodule

// File: rtl/xrom_bridge.sv
module xrom_bridge
  import xrom_pkg::*;
#(
  parameter logic [BASE_W-1:0] BOOT_BASE  = '1,
  parameter logic [WAIT_W-1:0] BOOT_WAIT  = '1,
  parameter logic [WAIT_W-1:0] BOOT_PWAIT = '1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pwr_good,
  input  logic [1:0]           strap_width,
  input  logic                 strap_bus,
  input  logic                 cfg_we,
  input  logic [IDX_W-1:0]     cfg_sel,
  input  logic [CFG_W-1:0]     cfg_wdata,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [HWA_W-1:0]     req_waddr,
  input  logic [31:0]          req_wdata,
  output logic                 resp_valid,
  output logic [31:0]          resp_rdata,
  output logic                 resp_err,
  output logic                 cfg_err,
  output logic                 acc_err,
  output logic [NWIN-1:0]      rom_cs_n,
  output logic                 rom_oe_n,
  output logic                 rom_we_n,
  output logic [ADDR_W-1:0]    rom_addr,
  output logic [31:0]          rom_dout,
  input  logic [31:0]          rom_din,
  output logic                 rom_dbus_sel
);
  logic rs1_q, rs2_q, rst_sync_n;
  win_cfg_t [NWIN-1:0] cfg_all;
  logic [NWIN-1:0] win_en;
  logic [NWIN-1:0][BASE_W-1:0] win_base;
  logic dec_hit;
  logic [IDX_W-1:0] dec_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_sync_n = rs2_q;

  xrom_cfg_regs #(
    .BOOT_BASE(BOOT_BASE), .BOOT_WAIT(BOOT_WAIT), .BOOT_PWAIT(BOOT_PWAIT)
  ) u_cfg (
    .clk(clk), .rst_n(rst_sync_n), .pwr_good(pwr_good),
    .strap_width(strap_width), .strap_bus(strap_bus),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_o(cfg_all), .cfg_err(cfg_err)
  );

  for (genvar gi = 0; gi < NWIN; gi++) begin : g_split
    assign win_en[gi]   = cfg_all[gi].en;
    assign win_base[gi] = cfg_all[gi].base;
  end

  xrom_decode u_dec (
    .win_en(win_en), .win_base(win_base),
    .hi_addr(req_waddr[HWA_W-1 -: BASE_W]),
    .hit(dec_hit), .idx(dec_idx)
  );

  xrom_seq u_seq (
    .clk(clk), .rst_n(rst_sync_n),
    .req_valid(req_valid), .req_write(req_write),
    .req_wlo(req_waddr[ADDR_W-3:0]), .req_wdata(req_wdata),
    .dec_hit(dec_hit), .dec_idx(dec_idx), .dec_acc(cfg_all[dec_idx].acc),
    .cfg_touch(cfg_we),
    .req_ready(req_ready), .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .resp_err(resp_err), .acc_err(acc_err),
    .rom_cs_n(rom_cs_n), .rom_oe_n(rom_oe_n), .rom_we_n(rom_we_n),
    .rom_addr(rom_addr), .rom_dout(rom_dout), .rom_din(rom_din),
    .rom_dbus_sel(rom_dbus_sel)
  );
endmodule

// File: tb/xrom_bridge_test.sv
module xrom_bridge_test;
  logic clk, rst_n, pwr_good, strap_bus, cfg_we;
  logic [1:0] strap_width, cfg_sel;
  logic [17:0] cfg_wdata;
  logic req_valid, req_ready, req_write, resp_valid, resp_err, cfg_err, acc_err;
  logic [29:0] req_waddr;
  logic [31:0] req_wdata, resp_rdata, rom_dout, rom_din;
  logic [2:0] rom_cs_n;
  logic rom_oe_n, rom_we_n, rom_dbus_sel;
  logic [25:0] rom_addr;

  xrom_bridge uut (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .strap_width(strap_width),
    .strap_bus(strap_bus), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_waddr(req_waddr), .req_wdata(req_wdata), .resp_valid(resp_valid),
    .resp_rdata(resp_rdata), .resp_err(resp_err), .cfg_err(cfg_err), .acc_err(acc_err),
    .rom_cs_n(rom_cs_n), .rom_oe_n(rom_oe_n), .rom_we_n(rom_we_n), .rom_addr(rom_addr),
    .rom_dout(rom_dout), .rom_din(rom_din), .rom_dbus_sel(rom_dbus_sel)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, issued = 0, seen = 0;
  int we_cyc = 0, oe_cyc = 0;
  logic [31:0] wd_first, wd_last;
  logic [2:0] exp_cs;
  logic exp_bus;

  typedef struct {
    logic [31:0] data;
    logic        err;
    logic        chk_data;
    int          lat;
    int          t0;
    string       rq;
  } item_t;
  item_t sb[$];

  // bench mirror of the window settings
  bit   m_en[3];
  int   m_w[3], m_fw[3], m_pw[3];
  bit   m_bus[3], m_pg[3], m_wp[3];
  logic [5:0] m_base[3];
  bit   bp_v; int bp_win; logic [22:0] bp_tag;

  function automatic logic [7:0] mb(input logic [25:0] a);
    return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'hC3;
  endfunction
  function automatic logic [31:0] mword(input logic [25:0] a);
    return {mb(a + 26'd3), mb(a + 26'd2), mb(a + 26'd1), mb(a)};
  endfunction
  assign rom_din = mword(rom_addr);

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 60000) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // monitor: strobes, chip selects and the scoreboard
  always @(negedge clk) begin
    if (rom_cs_n != 3'b111) begin
      chk((~rom_cs_n) == exp_cs, "R3/R11", "chip select", {29'd0, ~rom_cs_n}, {29'd0, exp_cs});
      chk(rom_dbus_sel == exp_bus, "R10", "bus select", {31'd0, rom_dbus_sel}, {31'd0, exp_bus});
    end
    if (!rom_we_n) begin
      if (we_cyc == 0) wd_first = rom_dout;
      wd_last = rom_dout;
      we_cyc++;
    end
    if (!rom_oe_n) oe_cyc++;
    if (resp_valid) begin
      item_t it;
      if (sb.size() == 0) begin
        chk(0, "R5", "unexpected response", 32'd1, 32'd0);
      end else begin
        it = sb.pop_front();
        chk(resp_err == it.err, it.rq, "resp_err", {31'd0, resp_err}, {31'd0, it.err});
        chk((cyc - it.t0) == it.lat, it.rq, "latency", cyc - it.t0, it.lat);
        if (it.chk_data)
          chk(resp_rdata == it.data, it.rq, "read data", resp_rdata, it.data);
      end
      seen++;
    end
  end

  function automatic logic [17:0] mk(input bit en, input int w, input bit bus, input bit pg,
                                     input bit wp, input int fw, input int pw, input logic [5:0] base);
    return {base, 3'(pw), 3'(fw), wp, pg, bus, 2'(w), en};
  endfunction

  task automatic cfg_wr(input int sel, input bit en, input int w, input bit bus, input bit pg,
                        input bit wp, input int fw, input int pw, input logic [5:0] base);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_wdata = mk(en, w, bus, pg, wp, fw, pw, base);
    @(posedge clk); #1;
    cfg_we = 1'b0;
    bp_v = 0;
    m_pg[sel] = pg; m_wp[sel] = wp; m_fw[sel] = fw; m_pw[sel] = pw;
    if (sel != 0) begin
      m_w[sel] = w; m_bus[sel] = bus; m_base[sel] = base;
      m_en[sel] = en && (w == 0 || w == 1 || (w == 2 && bus));
    end
  endtask

  task automatic do_req(input bit wr, input logic [31:0] addr, input logic [31:0] wd, input string rq);
    item_t it;
    int win, nb, bw;
    logic [25:0] a, ba;
    bit hit;
    win = -1;
    for (int i = 2; i >= 0; i--) if (m_en[i] && m_base[i] == addr[31:26]) win = i;
    a = {addr[25:2], 2'b00};
    it.err = (win < 0) || (wr && m_wp[win]);
    it.chk_data = !wr && !it.err;
    it.data = mword(a);
    it.rq = rq;
    it.lat = 0;
    exp_cs = 3'b000;
    exp_bus = 1'b0;
    nb = 1; bw = 4;
    if (it.err) begin
      bp_v = 0;
    end else begin
      exp_cs = 3'(1 << win);
      exp_bus = m_bus[win];
      bw = (m_w[win] == 0) ? 1 : (m_w[win] == 1) ? 2 : 4;
      nb = 4 / bw;
      for (int b = 0; b < nb; b++) begin
        ba = a + 26'(b * bw);
        hit = !wr && m_pg[win] && bp_v && bp_win == win && bp_tag == ba[25:3];
        it.lat += (hit ? m_pw[win] : m_fw[win]) + 1;
        if (!wr) begin bp_v = 1; bp_win = win; bp_tag = ba[25:3]; end
      end
      if (wr) bp_v = 0;
    end
    @(negedge clk);
    we_cyc = 0; oe_cyc = 0;
    req_valid = 1'b1; req_write = wr; req_waddr = addr[31:2]; req_wdata = wd;
    @(posedge clk); #1;
    req_valid = 1'b0;
    it.t0 = cyc;
    sb.push_back(it);
    issued++;
    while (seen != issued) @(negedge clk);
    if (it.err) begin
      chk(we_cyc == 0 && oe_cyc == 0, rq, "strobe on error", we_cyc + oe_cyc, 0);
    end else if (wr) begin
      logic [31:0] msk;
      msk = (bw == 4) ? 32'hFFFF_FFFF : (bw == 2) ? 32'h0000_FFFF : 32'h0000_00FF;
      chk(we_cyc == it.lat, "R9", "we_n low cycles", we_cyc, it.lat);
      chk(oe_cyc == 0, "R9", "oe_n during write", oe_cyc, 0);
      chk((wd_first & msk) == (wd & msk), "R9", "first beat lanes", wd_first & msk, wd & msk);
      chk((wd_last & msk) == ((wd >> (8 * (4 - bw))) & msk), "R9", "last beat lanes",
          wd_last & msk, (wd >> (8 * (4 - bw))) & msk);
    end else begin
      chk(we_cyc == 0, "R11", "we_n during read", we_cyc, 0);
    end
  endtask

  initial begin
    rst_n = 1'b0; pwr_good = 1'b0; strap_width = 2'd1; strap_bus = 1'b0;
    cfg_we = 1'b0; cfg_sel = 2'd0; cfg_wdata = '0;
    req_valid = 1'b0; req_write = 1'b0; req_waddr = '0; req_wdata = '0;
    exp_cs = 3'b000; exp_bus = 1'b0; bp_v = 0; bp_win = 0; bp_tag = '0;
    for (int i = 0; i < 3; i++) begin
      m_en[i] = 0; m_w[i] = 0; m_bus[i] = 0; m_pg[i] = 0; m_wp[i] = 0;
      m_fw[i] = 0; m_pw[i] = 0; m_base[i] = '0;
    end
    m_base[0] = 6'h3F; m_fw[0] = 7; m_pw[0] = 7;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(req_ready === 1'b1, "R1", "req_ready", {31'd0, req_ready}, 1);
    chk(rom_cs_n === 3'b111 && rom_oe_n === 1'b1 && rom_we_n === 1'b1, "R1", "strobes idle",
        {27'd0, rom_cs_n, rom_oe_n, rom_we_n}, 32'h1F);
    chk(resp_valid === 1'b0 && cfg_err === 1'b0 && acc_err === 1'b0, "R1", "flags clear",
        {29'd0, resp_valid, cfg_err, acc_err}, 0);

    // R2: boot window disabled before power good
    do_req(0, 32'hFC00_0000, 0, "R2");
    chk(acc_err === 1'b1, "R8", "acc_err after miss", {31'd0, acc_err}, 1);

    pwr_good = 1'b1;
    repeat (6) @(negedge clk);
    m_en[0] = 1; m_w[0] = 1; m_bus[0] = 0;
    strap_width = 2'd2; strap_bus = 1'b1;   // must be ignored now
    repeat (4) @(negedge clk);
    do_req(0, 32'hFC00_0010, 0, "R2");       // 16-bit boot: 2 beats of 8 cycles
    chk(cfg_err === 1'b0, "R4", "cfg_err after legal strap", {31'd0, cfg_err}, 0);

    // R5/R7: 8-bit window with page mode
    cfg_wr(1, 1, 0, 0, 1, 0, 5, 1, 6'h10);
    do_req(0, 32'h4000_0100, 0, "R7");        // 6+2+2+2
    do_req(0, 32'h4000_0104, 0, "R7");        // all page beats
    do_req(0, 32'h4000_0108, 0, "R7");        // page crossing

    // R5/R10: 16-bit window on the SDRAM data bus, unaligned low bits dropped
    cfg_wr(2, 1, 1, 1, 0, 0, 2, 0, 6'h20);
    do_req(0, 32'h8000_0202, 0, "R5");
    do_req(1, 32'h8000_0300, 32'hA1B2_C3D4, "R9");

    // R8: protected boot write
    cfg_wr(0, 0, 0, 0, 0, 1, 7, 7, 6'h00);
    do_req(1, 32'hFC00_0020, 32'h1234_5678, "R8");
    chk(acc_err === 1'b1, "R8", "acc_err sticky", {31'd0, acc_err}, 1);

    // R4: 32-bit on the general-purpose bus is refused
    cfg_wr(1, 1, 2, 0, 0, 0, 1, 1, 6'h10);
    chk(cfg_err === 1'b1, "R4", "cfg_err set", {31'd0, cfg_err}, 1);
    do_req(0, 32'h4000_0000, 0, "R4");
    // width code 3 also refused; error stays set
    cfg_wr(1, 1, 3, 1, 0, 0, 1, 1, 6'h10);
    chk(cfg_err === 1'b1, "R4", "cfg_err sticky", {31'd0, cfg_err}, 1);

    // R6: 32-bit window with zero wait
    cfg_wr(2, 1, 2, 1, 0, 0, 0, 0, 6'h20);
    do_req(0, 32'h8000_0040, 0, "R6");

    // R3: priority of window 1 over window 2 at the same base
    cfg_wr(1, 1, 0, 0, 0, 0, 1, 0, 6'h20);
    do_req(0, 32'h8000_0000, 0, "R3");
    do_req(0, 32'h0400_0000, 0, "R3");        // no window

    // R7: a write closes the page
    cfg_wr(1, 1, 0, 0, 1, 0, 3, 0, 6'h10);
    do_req(0, 32'h4000_0010, 0, "R7");
    do_req(1, 32'h4000_0014, 32'hCAFE_F00D, "R9");
    do_req(0, 32'h4000_0014, 0, "R7");
    do_req(0, 32'h4000_0010, 0, "R7");        // same page, now open

    repeat (4) @(negedge clk);
    chk(sb.size() == 0, "R5", "scoreboard drained", sb.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule